// File: doc/BRIEF.md
# Segment Descriptor Fetch Engine

This unit turns a 16-bit segment selector into a decoded segment descriptor. It picks the global or the local descriptor table from the selector, checks that the whole 8-byte entry lies inside the table limit, and reads the entry as two 32-bit words over a single-outstanding memory port. It then decodes the base, the limit, the type and attribute bits, and the gate fields.

A present code or data descriptor also gets its accessed flag set in memory. The high word is read a second time and is written back only when the flag is still clear. Each fetch ends with a one-cycle done pulse and a status code. Privilege rules are left to the consumer of the decoded fields.

Top module: `seg_desc_fetch`

## Requirements
- R1: The selector splits into RPL (bits 1:0), table select (bit 2, 1 = local table) and byte offset (selector with bits 2:0 cleared). The first read goes to table base + offset and the second read to that address + 4.
- R2: Status codes are 0 ok, 1 null, 2 table invalid, 3 limit fault, 4 bad descriptor. A global-table selector with bits 15:3 all zero finishes with status 1, with done on the cycle after acceptance and no memory request.
- R3: A local-table selector while `ldt_valid_i` is low finishes with status 2 and makes no memory request.
- R4: When offset + 7 is greater than the selected table limit, the fetch finishes with status 3 and makes no memory request. An entry whose last byte equals the limit is accepted.
- R5: The base output is {high[31:24], high[7:0], low[31:16]}. Type is high[11:8], S (code/data) is high[12], DPL is high[14:13], P is high[15], D is high[22] and G is high[23].
- R6: The raw limit is {high[19:16], low[15:0]}. With G set, the limit is shifted left by 12 and its low 12 bits are filled with ones. Expand-down data (S=1, type[3]=0, type[2]=1) is shifted but not filled. 16-bit task-state types 1 and 3 are never scaled.
- R7: Gate types 4, 6, 7, 12, 14 and 15 are valid only when high[7:5] is zero, and status 4 is reported otherwise. The gate selector is low[31:16], the offset is {high[31:16], low[15:0]} and the parameter count is high[4:0].
- R8: System types 0, 8, 10 and 13 finish with status 4.
- R9: For a valid descriptor with S=1 and P=1, the high word is read again. If its bit 8 (accessed) is clear, it is written back with bit 8 set. Otherwise there is no write. System and non-present descriptors never cause a write.
- R10: A memory request holds its valid, address, write flag and data stable until it is accepted. Only one request is in flight, each read gets exactly one response, and a write gets none.
- R11: `done_o` is a one-cycle pulse. `req_ready_o` is low while a fetch is in progress and during the done cycle.
- R12: After reset, `req_ready_o` is high, and `done_o` and `mem_req_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Selector presented |
| req_ready_o | output | 1 | Unit idle, selector accepted |
| sel_i | input | 16 | Segment selector |
| gdt_base_i | input | ADDR_W | Global table base address |
| gdt_limit_i | input | LIM_W | Global table limit |
| ldt_base_i | input | ADDR_W | Local table base address |
| ldt_limit_i | input | LIM_W | Local table limit |
| ldt_valid_i | input | 1 | Local table descriptor usable |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | Request is a write |
| mem_req_addr_o | output | ADDR_W | Request byte address |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Fetch finished (pulse) |
| status_o | output | 3 | Result code |
| desc_base_o | output | 32 | Decoded base |
| desc_limit_o | output | 32 | Decoded, scaled limit |
| desc_type_o | output | 4 | Type field |
| desc_s_o | output | 1 | Code/data flag |
| desc_dpl_o | output | 2 | Descriptor privilege level |
| desc_p_o | output | 1 | Present flag |
| desc_d_o | output | 1 | Default size flag |
| desc_g_o | output | 1 | Granularity flag |
| gate_sel_o | output | 16 | Gate target selector |
| gate_off_o | output | 32 | Gate target offset |
| gate_cnt_o | output | 5 | Gate parameter count |

## Verification
The assertions assume a well-behaved memory side. Each accepted read gets exactly one `mem_rsp_valid_i` pulse on a later cycle, no response arrives without an outstanding read, and the table base, limit and valid inputs do not change while a fetch runs. The bench memory model answers every read exactly one cycle after acceptance and never answers a write. It toggles `mem_req_ready_i` every cycle so that the hold-until-accepted path is exercised, and it changes `ldt_valid_i` only between fetches while the unit is idle.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned SEL_W    = 16;
  localparam int unsigned ACC_BIT  = 8;

  typedef enum logic [2:0] {
    ST_OK    = 3'd0,
    ST_NULL  = 3'd1,
    ST_TINV  = 3'd2,
    ST_LIMIT = 3'd3,
    ST_BAD   = 3'd4
  } status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LO_REQ, S_LO_RSP, S_HI_REQ, S_HI_RSP,
    S_EVAL, S_AC_REQ, S_AC_RSP, S_WR_REQ
  } fsm_e;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] limit;
    logic [3:0]  typ;
    logic        s;
    logic [1:0]  dpl;
    logic        p;
    logic        d;
    logic        g;
    logic [15:0] gsel;
    logic [31:0] goff;
    logic [4:0]  gcnt;
    logic        valid;
  } desc_t;
endpackage

// File: rtl/seg_sel_check.sv
module seg_sel_check
  import seg_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LIM_W  = 32
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [LIM_W-1:0]  gdt_limit_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  input  logic [LIM_W-1:0]  ldt_limit_i,
  input  logic              ldt_valid_i,
  output logic              null_o,
  output logic              tinv_o,
  output logic              lim_flt_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned EW = LIM_W + 1;

  logic              ti;
  logic [SEL_W-1:0]  offset;
  logic [LIM_W-1:0]  lim;
  logic [ADDR_W-1:0] base;
  logic [EW-1:0]     last_byte;

  always_comb begin
    ti        = sel_i[2];
    offset    = {sel_i[SEL_W-1:3], 3'b000};
    lim       = ti ? ldt_limit_i : gdt_limit_i;
    base      = ti ? ldt_base_i  : gdt_base_i;
    last_byte = EW'(offset) + EW'(7);
    null_o    = !ti && (sel_i[SEL_W-1:3] == '0);
    tinv_o    = ti && !ldt_valid_i;
    lim_flt_o = last_byte > {1'b0, lim};
    addr_o    = base + ADDR_W'(offset);
  end
endmodule

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import seg_pkg::*;
(
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  output desc_t         desc_o
);
  logic [19:0] raw_lim;
  logic        tss16;
  logic        scale;
  logic        exp_dn;
  logic        gate_ok;

  always_comb begin
    desc_o.base  = {hi_i[31:24], hi_i[7:0], lo_i[31:16]};
    desc_o.typ   = hi_i[11:8];
    desc_o.s     = hi_i[12];
    desc_o.dpl   = hi_i[14:13];
    desc_o.p     = hi_i[15];
    desc_o.d     = hi_i[22];
    desc_o.g     = hi_i[23];
    desc_o.gsel  = lo_i[31:16];
    desc_o.goff  = {hi_i[31:16], lo_i[15:0]};
    desc_o.gcnt  = hi_i[4:0];

    raw_lim = {hi_i[19:16], lo_i[15:0]};
    tss16   = !desc_o.s && (desc_o.typ == 4'd1 || desc_o.typ == 4'd3);
    scale   = desc_o.g && !tss16;
    exp_dn  = desc_o.s && !desc_o.typ[3] && desc_o.typ[2];
    if (scale) desc_o.limit = {raw_lim, exp_dn ? 12'h000 : 12'hfff};
    else       desc_o.limit = {12'h000, raw_lim};

    gate_ok = (hi_i[7:5] == 3'b000);
    if (desc_o.s) desc_o.valid = 1'b1;
    else begin
      unique case (desc_o.typ)
        4'd0, 4'd8, 4'd10, 4'd13:               desc_o.valid = 1'b0;
        4'd4, 4'd6, 4'd7, 4'd12, 4'd14, 4'd15:  desc_o.valid = gate_ok;
        default:                                desc_o.valid = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LIM_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [15:0]       sel_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [LIM_W-1:0]  gdt_limit_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  input  logic [LIM_W-1:0]  ldt_limit_i,
  input  logic              ldt_valid_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_we_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [31:0]       mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [31:0]       mem_rsp_rdata_i,
  output logic              done_o,
  output logic [2:0]        status_o,
  output logic [31:0]       desc_base_o,
  output logic [31:0]       desc_limit_o,
  output logic [3:0]        desc_type_o,
  output logic              desc_s_o,
  output logic [1:0]        desc_dpl_o,
  output logic              desc_p_o,
  output logic              desc_d_o,
  output logic              desc_g_o,
  output logic [15:0]       gate_sel_o,
  output logic [31:0]       gate_off_o,
  output logic [4:0]        gate_cnt_o
);
  localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(4);

  fsm_e              state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     lo_q, hi_q, acc_q;
  logic              done_q;
  status_e           status_q;

  logic              sc_null, sc_tinv, sc_lim;
  logic [ADDR_W-1:0] sc_addr;
  desc_t             dec;

  seg_sel_check #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_sel (
    .sel_i       (sel_i),
    .gdt_base_i  (gdt_base_i),
    .gdt_limit_i (gdt_limit_i),
    .ldt_base_i  (ldt_base_i),
    .ldt_limit_i (ldt_limit_i),
    .ldt_valid_i (ldt_valid_i),
    .null_o      (sc_null),
    .tinv_o      (sc_tinv),
    .lim_flt_o   (sc_lim),
    .addr_o      (sc_addr)
  );

  seg_desc_decode u_dec (
    .lo_i   (lo_q),
    .hi_i   (hi_q),
    .desc_o (dec)
  );

  logic accept;
  assign req_ready_o = (state_q == S_IDLE) && !done_q;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      acc_q    <= '0;
      done_q   <= 1'b0;
      status_q <= ST_OK;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          if (sc_null || sc_tinv || sc_lim) begin
            done_q   <= 1'b1;
            status_q <= sc_null ? ST_NULL : (sc_tinv ? ST_TINV : ST_LIMIT);
          end else begin
            addr_q  <= sc_addr;
            state_q <= S_LO_REQ;
          end
        end
        S_LO_REQ: if (mem_req_ready_i) state_q <= S_LO_RSP;
        S_LO_RSP: if (mem_rsp_valid_i) begin
          lo_q    <= mem_rsp_rdata_i;
          state_q <= S_HI_REQ;
        end
        S_HI_REQ: if (mem_req_ready_i) state_q <= S_HI_RSP;
        S_HI_RSP: if (mem_rsp_valid_i) begin
          hi_q    <= mem_rsp_rdata_i;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          if (!dec.valid) begin
            done_q   <= 1'b1;
            status_q <= ST_BAD;
            state_q  <= S_IDLE;
          end else if (dec.s && dec.p) begin
            state_q <= S_AC_REQ;
          end else begin
            done_q   <= 1'b1;
            status_q <= ST_OK;
            state_q  <= S_IDLE;
          end
        end
        S_AC_REQ: if (mem_req_ready_i) state_q <= S_AC_RSP;
        S_AC_RSP: if (mem_rsp_valid_i) begin
          if (mem_rsp_rdata_i[ACC_BIT]) begin
            done_q   <= 1'b1;
            status_q <= ST_OK;
            state_q  <= S_IDLE;
          end else begin
            acc_q   <= mem_rsp_rdata_i;
            state_q <= S_WR_REQ;
          end
        end
        S_WR_REQ: if (mem_req_ready_i) begin
          done_q   <= 1'b1;
          status_q <= ST_OK;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid_o = (state_q == S_LO_REQ) || (state_q == S_HI_REQ) ||
                      (state_q == S_AC_REQ) || (state_q == S_WR_REQ);
    mem_req_we_o    = (state_q == S_WR_REQ);
    mem_req_addr_o  = (state_q == S_LO_REQ) ? addr_q : addr_q + HI_OFS;
    mem_req_wdata_o = acc_q | (DW'(1) << ACC_BIT);
  end

  assign done_o       = done_q;
  assign status_o     = status_q;
  assign desc_base_o  = dec.base;
  assign desc_limit_o = dec.limit;
  assign desc_type_o  = dec.typ;
  assign desc_s_o     = dec.s;
  assign desc_dpl_o   = dec.dpl;
  assign desc_p_o     = dec.p;
  assign desc_d_o     = dec.d;
  assign desc_g_o     = dec.g;
  assign gate_sel_o   = dec.gsel;
  assign gate_off_o   = dec.goff;
  assign gate_cnt_o   = dec.gcnt;
endmodule

// File: rtl/seg_desc_fetch_chk.sv
module seg_desc_fetch_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LIM_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [15:0]       sel_i,
  input logic [LIM_W-1:0]  gdt_limit_i,
  input logic [LIM_W-1:0]  ldt_limit_i,
  input logic              ldt_valid_i,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic              mem_req_we_o,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic [31:0]       mem_req_wdata_o,
  input logic              done_o,
  input logic [2:0]        status_o
);
  logic             acc;
  logic             is_null;
  logic [LIM_W:0]   last_b;
  logic [LIM_W-1:0] lim;

  always_comb begin
    acc     = req_valid_i && req_ready_o;
    is_null = !sel_i[2] && (sel_i[15:3] == 13'd0);
    lim     = sel_i[2] ? ldt_limit_i : gdt_limit_i;
    last_b  = (LIM_W+1)'({sel_i[15:3], 3'b000}) + (LIM_W+1)'(7);
  end

  AST_NULL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && is_null |=> done_o && status_o == 3'd1 && !mem_req_valid_o); // R2
  AST_TINV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && sel_i[2] && !ldt_valid_i |=> done_o && status_o == 3'd2 && !mem_req_valid_o); // R3
  AST_LIMIT_FLT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !is_null && !(sel_i[2] && !ldt_valid_i) && (last_b > {1'b0, lim})
    |=> done_o && status_o == 3'd3 && !mem_req_valid_o); // R4
  AST_WR_SETS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_we_o |-> mem_req_wdata_o[8]); // R9
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o &&
    $stable(mem_req_addr_o) && $stable(mem_req_we_o) && $stable(mem_req_wdata_o)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o || done_o |-> !req_ready_o); // R11
endmodule

bind seg_desc_fetch seg_desc_fetch_chk #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .sel_i           (sel_i),
  .gdt_limit_i     (gdt_limit_i),
  .ldt_limit_i     (ldt_limit_i),
  .ldt_valid_i     (ldt_valid_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_we_o    (mem_req_we_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_wdata_o (mem_req_wdata_o),
  .done_o          (done_o),
  .status_o        (status_o)
);

// File: tb/seg_desc_fetch_tb.sv
module seg_desc_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] sel = '0;
  logic [31:0] gdt_base = 32'h0, ldt_base = 32'h80;
  logic [31:0] gdt_limit = 32'h3f, ldt_limit = 32'h17;
  logic        ldt_valid = 1'b1;
  logic        m_valid, m_ready, m_we, r_valid;
  logic [31:0] m_addr, m_wdata, r_data;
  logic        done;
  logic [2:0]  status;
  logic [31:0] d_base, d_limit, g_off;
  logic [3:0]  d_type;
  logic        d_s, d_p, d_d, d_g;
  logic [1:0]  d_dpl;
  logic [15:0] g_sel;
  logic [4:0]  g_cnt;

  int checks = 0, errors = 0;
  bit fin = 0;

  always #10 clk = ~clk;

  seg_desc_fetch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .sel_i(sel), .gdt_base_i(gdt_base), .gdt_limit_i(gdt_limit),
    .ldt_base_i(ldt_base), .ldt_limit_i(ldt_limit), .ldt_valid_i(ldt_valid),
    .mem_req_valid_o(m_valid), .mem_req_ready_i(m_ready), .mem_req_we_o(m_we),
    .mem_req_addr_o(m_addr), .mem_req_wdata_o(m_wdata),
    .mem_rsp_valid_i(r_valid), .mem_rsp_rdata_i(r_data),
    .done_o(done), .status_o(status), .desc_base_o(d_base), .desc_limit_o(d_limit),
    .desc_type_o(d_type), .desc_s_o(d_s), .desc_dpl_o(d_dpl), .desc_p_o(d_p),
    .desc_d_o(d_d), .desc_g_o(d_g), .gate_sel_o(g_sel), .gate_off_o(g_off),
    .gate_cnt_o(g_cnt)
  );

  // memory model: 64 words, read data one cycle after acceptance, ready toggles
  logic [31:0] mem [64];
  int          n_rd, n_wr;
  logic [31:0] first_rd, last_wd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ready <= 1'b1;
      r_valid <= 1'b0;
      r_data  <= '0;
    end else begin
      m_ready <= ~m_ready;
      r_valid <= 1'b0;
      if (m_valid && m_ready) begin
        if (m_we) begin
          mem[m_addr[7:2]] <= m_wdata;
          n_wr    <= n_wr + 1;
          last_wd <= m_wdata;
        end else begin
          r_valid <= 1'b1;
          r_data  <= mem[m_addr[7:2]];
          if (n_rd == 0) first_rd <= m_addr;
          n_rd <= n_rd + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] s);
    int t;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n_rd = 0; n_wr = 0; first_rd = '0; last_wd = '0;
    sel = s; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
  endtask

  typedef struct packed {
    logic [15:0] s;
    logic [2:0]  st;
    logic [31:0] base;
    logic [31:0] lim;
    logic [3:0]  rd;
    logic [31:0] addr;
    logic        wr;
    logic [31:0] wd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h0008, 3'd0, 32'h12345678, 32'h0005abcd, 4'd3, 32'h08, 1'b1, 32'h12459334}, // R5 R9
    '{16'h0013, 3'd0, 32'h00000000, 32'hffffffff, 4'd3, 32'h10, 1'b0, 32'h0},        // R6 R9
    '{16'h0018, 3'd0, 32'h00000000, 32'h00010000, 4'd3, 32'h18, 1'b1, 32'h00809700}, // R6
    '{16'h0020, 3'd0, 32'h00000000, 32'h00000100, 4'd2, 32'h20, 1'b0, 32'h0},        // R9
    '{16'h0028, 3'd4, 32'h0,        32'h0,        4'd2, 32'h28, 1'b0, 32'h0},        // R8
    '{16'h003b, 3'd4, 32'h0,        32'h0,        4'd2, 32'h38, 1'b0, 32'h0},        // R7 R4
    '{16'h0040, 3'd3, 32'h0,        32'h0,        4'd0, 32'h0,  1'b0, 32'h0},        // R4
    '{16'h0003, 3'd1, 32'h0,        32'h0,        4'd0, 32'h0,  1'b0, 32'h0},        // R2
    '{16'h0004, 3'd0, 32'h00000000, 32'h00000fff, 4'd3, 32'h80, 1'b0, 32'h0},        // R1
    '{16'h0014, 3'd0, 32'h00000000, 32'h00000020, 4'd2, 32'h90, 1'b0, 32'h0},        // R1 R9
    '{16'h001c, 3'd3, 32'h0,        32'h0,        4'd0, 32'h0,  1'b0, 32'h0}         // R4
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!fin) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[2]  = 32'h5678abcd; mem[3]  = 32'h12459234;
    mem[4]  = 32'h0000ffff; mem[5]  = 32'h00cffb00;
    mem[6]  = 32'h00000010; mem[7]  = 32'h00809600;
    mem[8]  = 32'h00000100; mem[9]  = 32'h00001200;
    mem[10] = 32'h00000000; mem[11] = 32'h00008800;
    mem[12] = 32'h0040beef; mem[13] = 32'hdead8c03;
    mem[14] = 32'h00000000; mem[15] = 32'h00008e20;
    mem[32] = 32'h00000fff; mem[33] = 32'h00409300;
    mem[36] = 32'h00000020; mem[37] = 32'h00008200;
    n_rd = 0; n_wr = 0;

    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 ready", 32'(req_ready), 32'd1);
    chk("R12 done", 32'(done), 32'd0);
    chk("R12 mem_valid", 32'(m_valid), 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      run(VECS[v].s);
      chk($sformatf("R2 status v%0d", v), 32'(status), 32'(VECS[v].st));
      chk($sformatf("R10 reads v%0d", v), 32'(n_rd), 32'(VECS[v].rd));
      if (VECS[v].rd != 0) chk($sformatf("R1 addr v%0d", v), first_rd, VECS[v].addr);
      if (VECS[v].st == 3'd0) begin
        chk($sformatf("R5 base v%0d", v), d_base, VECS[v].base);
        chk($sformatf("R6 limit v%0d", v), d_limit, VECS[v].lim);
      end
      chk($sformatf("R9 write v%0d", v), 32'(n_wr), 32'(VECS[v].wr));
      if (VECS[v].wr) chk($sformatf("R9 wdata v%0d", v), last_wd, VECS[v].wd);
      @(negedge clk);
      chk($sformatf("R11 pulse v%0d", v), 32'(done), 32'd0);
    end

    // R5 attribute fields of the code descriptor at 0x10
    run(16'h0010);
    chk("R5 type", 32'(d_type), 32'hb);
    chk("R5 dpl", 32'(d_dpl), 32'd3);
    chk("R5 s/p/d/g", {28'd0, d_s, d_p, d_d, d_g}, 32'hf);

    // R7 valid gate fields
    run(16'h0030);
    chk("R7 status", 32'(status), 32'd0);
    chk("R7 gate sel", 32'(g_sel), 32'h0040);
    chk("R7 gate off", g_off, 32'hdeadbeef);
    chk("R7 gate cnt", 32'(g_cnt), 32'd3);
    chk("R9 gate no write", 32'(n_wr), 32'd0);

    // R9 second fetch of 0x08: accessed now set, no write
    run(16'h0008);
    chk("R9 refetch no write", 32'(n_wr), 32'd0);

    // R3 local table invalid
    @(negedge clk);
    ldt_valid = 1'b0;
    run(16'h0004);
    chk("R3 status", 32'(status), 32'd2);
    chk("R3 no access", 32'(n_rd + n_wr), 32'd0);
    ldt_valid = 1'b1;

    // R11 ready low while busy
    @(negedge clk);
    sel = 16'h0020; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 busy ready", 32'(req_ready), 32'd0);
    while (!done) @(negedge clk);
    chk("R11 done ready", 32'(req_ready), 32'd0);

    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule